// File: doc/BRIEF.md
# PWM Pin Override Arbiter

This block sits between a PWM waveform source and the output pins of one generator. Three override requesters feed it: a fault input, a current-limit input and a feed-forward input. Each requester carries its own preset that can force the high pin, the low pin, or both, to a chosen level. When no requester is active, the pins follow the normal PWM high/low pair. When several requesters are active together, a fixed priority decides whose preset applies. A 2-bit code reports the current winner.

Forcing a pin low (inactive) is purely combinational from the raw request. It takes effect with no clock edge, so a fault puts the pins in a safe state even if the clock is stopped. Forcing a pin high (active) is normally combinational as well. When dead-time insertion is enabled downstream, the active path instead uses a two-flop synchronized copy of the requests, so the dead-time logic sees edges aligned to the clock.

A fourth input, the sync request, is only passed through the same synchronizer as a trigger output and never touches the pins.

Top module: `pwm_override_arbiter`

## Requirements
- R1: While `rst_n` is low, the synchronizer is cleared. With no request active, `out_hi`/`out_lo` equal `pwm_hi`/`pwm_lo`, `win_code` is 0 and `sync_trig` is 0.
- R2: `win_code` is combinational and encodes the winner as 1 for fault, 2 for current limit, 3 for feed-forward and 0 for none. Fault beats current limit, and current limit beats feed-forward.
- R3: Each preset is 4 bits: bit 3 enables override of the high pin, bit 2 enables override of the low pin, bit 1 is the forced high-pin level and bit 0 is the forced low-pin level. A winner whose enable bit for a pin is clear leaves that pin following its PWM input.
- R4: If the raw winner enables a pin with forced level 0, that pin is 0 in the same cycle, with no clock edge needed, whatever the value of `dt_en`.
- R5: With `dt_en` low, if the raw winner enables a pin with forced level 1, that pin is 1 with no clock edge needed.
- R6: With `dt_en` high, forcing a pin to 1 follows the winner among the synchronized requests. A request held from before a rising edge takes effect after the second rising edge. After the request is removed, its effect remains until the second rising edge.
- R7: Once the requests have been stable for two rising edges, the preset of a requester outranked by an active higher-priority requester has no effect on the pins.
- R8: `sync_in` never changes `out_hi`, `out_lo` or `win_code`. `sync_trig` equals `sync_in` as sampled two rising edges earlier.
- R9: With no request active in the raw inputs and none in the synchronized copy, the pins equal the PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | Normal high-side PWM value |
| pwm_lo | input | 1 | Normal low-side PWM value |
| dt_en | input | 1 | Dead-time in use: active forcing uses the synchronized requests |
| req_fault | input | 1 | Fault requester active (highest priority) |
| req_climit | input | 1 | Current-limit requester active |
| req_ffwd | input | 1 | Feed-forward requester active (lowest priority) |
| sync_in | input | 1 | Trigger request, never an override |
| cfg_fault | input | 4 | Fault preset {en_hi, en_lo, lvl_hi, lvl_lo} |
| cfg_climit | input | 4 | Current-limit preset, same layout |
| cfg_ffwd | input | 4 | Feed-forward preset, same layout |
| out_hi | output | 1 | Final high pin state |
| out_lo | output | 1 | Final low pin state |
| win_code | output | 2 | Winning requester code |
| sync_trig | output | 1 | Synchronized trigger |

## Verification
The only state is the two-stage synchronizer. A wrong value there shows up only with `dt_en` high, as a forced-high pin that arrives one edge early, one edge late, or never, and as a lingering high after a request is released. The bench therefore checks the pins both between edges and just after each rising edge against a model of the two-edge delay. Priority and inactive-forcing errors are purely combinational and appear at the pins before the next edge, so they are checked right after each input change.

// File: rtl/pwm_override_arbiter.sv
module pwm_override_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_hi,
  input  logic       pwm_lo,
  input  logic       dt_en,
  input  logic       req_fault,
  input  logic       req_climit,
  input  logic       req_ffwd,
  input  logic       sync_in,
  input  logic [3:0] cfg_fault,
  input  logic [3:0] cfg_climit,
  input  logic [3:0] cfg_ffwd,
  output logic       out_hi,
  output logic       out_lo,
  output logic [1:0] win_code,
  output logic       sync_trig
);

  // bit order: 0 fault, 1 current limit, 2 feed-forward, 3 sync trigger
  logic [3:0] stg_a, stg_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a <= '0;
      stg_b <= '0;
    end else begin
      stg_a <= {sync_in, req_ffwd, req_climit, req_fault};
      stg_b <= stg_a;
    end
  end

  function automatic logic [3:0] pick(input logic [2:0] r, input logic [3:0] f,
                                      input logic [3:0] c, input logic [3:0] w);
    if (r[0])      pick = f;
    else if (r[1]) pick = c;
    else if (r[2]) pick = w;
    else           pick = 4'b0000;
  endfunction

  logic [3:0] raw_sel, syn_sel, act_sel;
  logic       kill_hi, kill_lo, drive_hi, drive_lo;

  assign raw_sel  = pick({req_ffwd, req_climit, req_fault}, cfg_fault, cfg_climit, cfg_ffwd);
  assign syn_sel  = pick(stg_b[2:0], cfg_fault, cfg_climit, cfg_ffwd);
  assign act_sel  = dt_en ? syn_sel : raw_sel;

  // inactive forcing: raw request, no clock involved
  assign kill_hi  = raw_sel[3] & ~raw_sel[1];
  assign kill_lo  = raw_sel[2] & ~raw_sel[0];
  // active forcing: raw or synchronized, per dt_en
  assign drive_hi = act_sel[3] & act_sel[1];
  assign drive_lo = act_sel[2] & act_sel[0];

  assign out_hi    = ~kill_hi & (drive_hi | pwm_hi);
  assign out_lo    = ~kill_lo & (drive_lo | pwm_lo);
  assign win_code  = req_fault ? 2'd1 : req_climit ? 2'd2 : req_ffwd ? 2'd3 : 2'd0;
  assign sync_trig = stg_b[3];

  assert_kill_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fault && cfg_fault[3] && !cfg_fault[1]) |-> !out_hi);

  assert_kill_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fault && cfg_fault[2] && !cfg_fault[0]) |-> !out_lo);

  assert_fault_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fault |-> (win_code == 2'd1));

  assert_climit_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_climit && !req_fault) |-> (win_code == 2'd2));

  assert_idle_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_fault && !req_climit && !req_ffwd && stg_b[2:0] == 3'b000)
      |-> (out_hi == pwm_hi && out_lo == pwm_lo));

  assert_trig_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_trig) |-> $past(sync_in, 2));

endmodule

// File: tb/pwm_override_arbiter_test.sv
`timescale 1ns/1ps
module pwm_override_arbiter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_hi = 0, pwm_lo = 0, dt_en = 0, sync_in = 0;
  logic req_fault = 0, req_climit = 0, req_ffwd = 0;
  logic [3:0] cfg_fault = 0, cfg_climit = 0, cfg_ffwd = 0;
  logic out_hi, out_lo, sync_trig;
  logic [1:0] win_code;
  int checks = 0, failures = 0;
  logic [3:0] m1 = 0, m2 = 0;  // model of requests seen one and two edges back

  always #5 clk = ~clk;

  pwm_override_arbiter uut (.*);

  function automatic logic [3:0] winner_cfg(input logic f, input logic c, input logic w);
    case (1'b1)
      f: return cfg_fault;
      c: return cfg_climit;
      w: return cfg_ffwd;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic exp_pin(input logic side_hi);
    logic [3:0] rw, ac;
    logic en_r, lv_r, en_a, lv_a, p;
    rw = winner_cfg(req_fault, req_climit, req_ffwd);
    ac = dt_en ? winner_cfg(m2[0], m2[1], m2[2]) : rw;
    en_r = side_hi ? rw[3] : rw[2];
    lv_r = side_hi ? rw[1] : rw[0];
    en_a = side_hi ? ac[3] : ac[2];
    lv_a = side_hi ? ac[1] : ac[0];
    p    = side_hi ? pwm_hi : pwm_lo;
    if (en_r && !lv_r) return 1'b0;   // R4
    if (en_a && lv_a)  return 1'b1;   // R5 / R6
    return p;                         // R3 / R9
  endfunction

  function automatic logic [1:0] exp_code();
    if (req_fault)  return 2'd1;
    if (req_climit) return 2'd2;
    if (req_ffwd)   return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " out_hi"}, {31'd0, out_hi}, {31'd0, exp_pin(1'b1)});
    chk({tag, " out_lo"}, {31'd0, out_lo}, {31'd0, exp_pin(1'b0)});
    chk("R2 win_code", {30'd0, win_code}, {30'd0, exp_code()});
    chk("R8 sync_trig", {31'd0, sync_trig}, {31'd0, m2[3]});
  endtask

  task automatic step(input string tag);
    #1 check_all(tag);
    @(posedge clk);
    m2 = m1;
    m1 = {sync_in, req_ffwd, req_climit, req_fault};
    #1 check_all(tag);
    @(negedge clk);
  endtask

  task automatic set_req(input logic f, input logic c, input logic w);
    req_fault = f; req_climit = c; req_ffwd = w;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    // R1: reset state
    pwm_hi = 1; pwm_lo = 0; sync_in = 1;
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    sync_in = 0; pwm_hi = 0;
    @(negedge clk);

    // R4: inactive forcing with no clock edge, dt_en high
    dt_en = 1; pwm_hi = 1; pwm_lo = 1;
    cfg_fault = 4'b1000;
    set_req(1, 0, 0);
    #1 chk("R4 immediate kill hi", {31'd0, out_hi}, 32'd0);
    step("R4");
    set_req(0, 0, 0);
    step("R4");

    // R6: active forcing waits two edges, lingers two edges after release
    pwm_hi = 0; pwm_lo = 0;
    cfg_ffwd = 4'b1111;
    set_req(0, 0, 1);
    #1 chk("R6 not yet forced", {31'd0, out_hi}, 32'd0);
    step("R6");
    chk("R6 one edge", {31'd0, out_hi}, 32'd0);
    step("R6");
    chk("R6 two edges", {31'd0, out_hi}, 32'd1);
    set_req(0, 0, 0);
    step("R6");
    chk("R6 release pending", {31'd0, out_lo}, 32'd1);
    step("R6");
    chk("R6 released", {31'd0, out_lo}, 32'd0);

    // R5: immediate active forcing with dt_en low
    dt_en = 0;
    cfg_climit = 4'b0101;
    set_req(0, 1, 0);
    #1 chk("R5 immediate drive lo", {31'd0, out_lo}, 32'd1);
    step("R5");

    // R7: outranked preset ignored once stable
    dt_en = 1; cfg_fault = 4'b0000; pwm_hi = 0; pwm_lo = 0;
    set_req(1, 1, 1);
    step("R7"); step("R7"); step("R7");
    chk("R7 lower preset ignored", {30'd0, out_hi, out_lo}, 32'd0);

    // R8: sync input does not touch pins
    set_req(0, 0, 0);
    step("R8"); step("R8");
    sync_in = 1;
    #1 chk("R8 pins unaffected", {30'd0, out_hi, out_lo}, 32'd0);
    step("R8"); step("R8");
    sync_in = 0;
    step("R8");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pwm_hi = r[0]; pwm_lo = r[1];
      if (r[4:2] == 0) dt_en = ~dt_en;
      sync_in = r[5];
      if (r[8:6] != 0) set_req(r[9] & r[10], r[11] & r[12], r[13]);
      if (r[16:14] == 0) begin
        cfg_fault  = 4'($urandom);
        cfg_climit = 4'($urandom);
        cfg_ffwd   = 4'($urandom);
      end
      step("R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule